// File: doc/BRIEF.md
# Smart Card Character Interface with Contact Sequencer

This block moves single characters between a host and an ISO 7816 card over one open-drain I/O line that both ends share, half duplex. A character is a low start bit, eight data bits sent least significant bit first, and an even parity bit. Each bit lasts one elementary time unit (ETU) of `ETU_CLKS` system clocks. In the character protocol (`cfg_t1` = 0) the block pulls the line low when a received character has bad parity. When it transmits and the card pulls the line low, it sends the same byte again, up to `cfg_retry_max` extra times. In the block protocol (`cfg_t1` = 1) error signalling is off in both directions, and a parity failure is only reported.

A second state machine drives the card contacts. `card_gnd`, `card_vcc`, `card_clk_en` and `card_rst_n` are separate outputs. The power-up and shutdown sequences step through them in a fixed order with programmed gaps. Characters can only move while the contacts are fully up (`card_ready`).

Sequencer states: SQ_OFF, SQ_GND, SQ_VCC, SQ_CLK, SQ_ACTIVE, SQ_RSTLO, SQ_CLKOFF, SQ_VCCOFF. The power-up path is SQ_OFF to SQ_GND to SQ_VCC to SQ_CLK to SQ_ACTIVE. The shutdown path is SQ_ACTIVE to SQ_RSTLO to SQ_CLKOFF to SQ_VCCOFF to SQ_OFF. `pwr_up_req` starts power-up and is taken only in SQ_OFF. `pwr_down_req` starts shutdown and is taken only in SQ_ACTIVE. Each gap state ends after its cycle count.

Character engine states: CH_IDLE, CH_TX_BITS, CH_TX_GUARD, CH_TX_BACKOFF, CH_RX_BITS, CH_RX_NAK, CH_RX_GUARD. The transitions are:
- CH_IDLE goes to CH_RX_BITS on a falling line edge, or to CH_TX_BITS on a write.
- CH_TX_BITS goes to CH_TX_GUARD after 10 ETU.
- CH_TX_GUARD goes to CH_TX_BACKOFF on a card error that still has a retry left. It goes to CH_IDLE at 12 ETU, or when it gives up.
- CH_TX_BACKOFF goes back to CH_TX_BITS at 13 ETU.
- CH_RX_BITS goes to CH_IDLE on a false start. At 10.5 ETU it goes to CH_RX_NAK or to CH_RX_GUARD.
- CH_RX_NAK goes to CH_RX_GUARD at 11.5 ETU.
- CH_RX_GUARD goes to CH_IDLE at 12 ETU.
- Every engine state falls back to CH_IDLE when `card_ready` drops.

Top module: `sc_char_if`

## Requirements
- R1: After a one-cycle `pwr_up_req` in SQ_OFF, `card_gnd` rises first. `card_vcc` rises `STEP_CLKS` cycles later, and `card_clk_en` rises `STEP_CLKS` cycles after that. `card_rst_n` rises `RST_HOLD_CLKS` cycles after the clock and `card_ready` rises with it.
- R2: After a one-cycle `pwr_down_req` in SQ_ACTIVE, `card_rst_n` and `card_ready` fall first. `card_clk_en` falls `STEP_CLKS` cycles later, then `card_vcc` falls `STEP_CLKS` cycles after that, then `card_gnd` falls `STEP_CLKS` cycles after that.
- R3: While `rst_n` is low, all four contact outputs are 0, `io_drive_low` is 0 and `busy` is 0.
- R4: A write accepted in CH_IDLE sends a frame on the line: a low start bit, `wr_data` least significant bit first, then an even parity bit, each bit `ETU_CLKS` cycles long. When no error is seen, `tx_done` pulses for one cycle at 12 ETU. `irq` is high in every cycle in which `rx_valid`, `rx_err`, `tx_done` or `tx_fail` is high.
- R5: A card frame with good parity is delivered as a one-cycle `rx_valid` pulse at 10.5 ETU. `rx_data` holds the byte, with the first data bit in bit 0, and `rx_par_err` is 0.
- R6: With `cfg_t1` = 0, a received frame with bad parity gives no `rx_valid`. Instead the line is driven low from 10.5 to 11.5 ETU and `rx_err` pulses.
- R7: With `cfg_t1` = 0, the block samples the line at 11 ETU of each transmitted frame. If it is low, the byte is sent again starting at 13 ETU, at most `cfg_retry_max` times. The next error after that ends the transfer: `tx_fail` pulses and `tx_giveup` is set. `tx_giveup` stays set until the next accepted write clears it.
- R8: With `cfg_t1` = 1, a frame with bad parity is delivered with `rx_valid` and `rx_par_err` = 1, and the line is not driven. A card error on a transmitted frame is ignored: the byte is sent once and `tx_done` pulses.
- R9: A write is ignored while `card_ready` is 0 or `busy` is 1, and the engine drops to CH_IDLE one cycle after `card_ready` falls.
- R10: If a falling line edge and `wr_en` are seen in the same cycle in CH_IDLE, the incoming frame is received and the written byte is dropped: no frame is ever sent for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_up_req | input | 1 | Start the power-up sequence (taken in SQ_OFF) |
| pwr_down_req | input | 1 | Start the shutdown sequence (taken in SQ_ACTIVE) |
| cfg_t1 | input | 1 | 1 selects the block protocol, with no error signalling |
| cfg_retry_max | input | RETRY_W | Maximum number of retransmissions per byte |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to transmit |
| io_in | input | 1 | Sensed level of the card I/O line |
| io_drive_low | output | 1 | 1 pulls the I/O line low (open drain) |
| card_gnd | output | 1 | Card ground switch enable |
| card_vcc | output | 1 | Card supply switch enable |
| card_clk_en | output | 1 | Card clock enable |
| card_rst_n | output | 1 | Card reset, active low |
| card_ready | output | 1 | Contacts fully up; characters may move |
| busy | output | 1 | Character engine not in CH_IDLE |
| rx_valid | output | 1 | One-cycle pulse: received byte available |
| rx_data | output | 8 | Received byte |
| rx_par_err | output | 1 | Parity failure flag that goes with `rx_valid` |
| rx_err | output | 1 | One-cycle pulse: bad frame refused with an error signal |
| tx_done | output | 1 | One-cycle pulse: byte accepted by the card |
| tx_fail | output | 1 | One-cycle pulse: retries used up |
| tx_giveup | output | 1 | Sticky flag for a failed transfer |
| irq | output | 1 | OR of the four event pulses |

## Verification
The same clock edge can carry both a host write and the card's start edge. In that case receive and transmit compete for the one line. The bench provokes this by starting a card frame on one falling clock edge and pulsing `wr_en` on the next, so that both are sampled by the same rising edge. The result is judged at the ports: the card byte must arrive through `rx_valid`, and the card model must never see a frame from the block, nor may `tx_done` pulse.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [2:0] {
        SQ_OFF, SQ_GND, SQ_VCC, SQ_CLK, SQ_ACTIVE, SQ_RSTLO, SQ_CLKOFF, SQ_VCCOFF
    } seq_state_e;

    typedef enum logic [2:0] {
        CH_IDLE, CH_TX_BITS, CH_TX_GUARD, CH_TX_BACKOFF, CH_RX_BITS, CH_RX_NAK, CH_RX_GUARD
    } chr_state_e;

    // Half-ETU marks counted from the start edge (the mark ends that half ETU)
    localparam logic [4:0] HM_START_CHK = 5'd0;
    localparam logic [4:0] HM_TX_LAST   = 5'd19;
    localparam logic [4:0] HM_DECIDE    = 5'd20;
    localparam logic [4:0] HM_ERR_SENSE = 5'd21;
    localparam logic [4:0] HM_NAK_END   = 5'd22;
    localparam logic [4:0] HM_GUARD_END = 5'd23;
    localparam logic [4:0] HM_RETRY     = 5'd25;

endpackage

// File: rtl/sc_contact_seq.sv
module sc_contact_seq
    import sc_pkg::*;
#(
    parameter int STEP_CLKS     = 4,
    parameter int RST_HOLD_CLKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_req,
    input  logic down_req,
    output logic gnd_on,
    output logic vcc_on,
    output logic clk_on,
    output logic rst_card_n,
    output logic ready
);
    localparam int MAXW = (STEP_CLKS > RST_HOLD_CLKS) ? STEP_CLKS : RST_HOLD_CLKS;
    localparam int WW   = $clog2(MAXW + 1);
    localparam logic [WW-1:0] STEP_LAST = WW'(STEP_CLKS - 1);
    localparam logic [WW-1:0] HOLD_LAST = WW'(RST_HOLD_CLKS - 1);

    seq_state_e st, st_nxt;
    logic [WW-1:0] wcnt;
    logic          gap_end;

    always_comb begin
        unique case (st)
            SQ_CLK:  gap_end = (wcnt == HOLD_LAST);
            default: gap_end = (wcnt == STEP_LAST);
        endcase
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            SQ_OFF:     if (up_req)   st_nxt = SQ_GND;
            SQ_GND:     if (gap_end)  st_nxt = SQ_VCC;
            SQ_VCC:     if (gap_end)  st_nxt = SQ_CLK;
            SQ_CLK:     if (gap_end)  st_nxt = SQ_ACTIVE;
            SQ_ACTIVE:  if (down_req) st_nxt = SQ_RSTLO;
            SQ_RSTLO:   if (gap_end)  st_nxt = SQ_CLKOFF;
            SQ_CLKOFF:  if (gap_end)  st_nxt = SQ_VCCOFF;
            SQ_VCCOFF:  if (gap_end)  st_nxt = SQ_OFF;
            default:                  st_nxt = SQ_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SQ_OFF;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              wcnt <= '0;
        else if (st_nxt != st)   wcnt <= '0;
        else if (!gap_end)       wcnt <= wcnt + 1'b1;
    end

    always_comb begin
        gnd_on     = 1'b0;
        vcc_on     = 1'b0;
        clk_on     = 1'b0;
        rst_card_n = 1'b0;
        unique case (st)
            SQ_OFF: ;
            SQ_GND, SQ_VCCOFF: gnd_on = 1'b1;
            SQ_VCC, SQ_CLKOFF: begin gnd_on = 1'b1; vcc_on = 1'b1; end
            SQ_CLK, SQ_RSTLO:  begin gnd_on = 1'b1; vcc_on = 1'b1; clk_on = 1'b1; end
            SQ_ACTIVE: begin
                gnd_on = 1'b1; vcc_on = 1'b1; clk_on = 1'b1; rst_card_n = 1'b1;
            end
            default: ;
        endcase
        ready = (st == SQ_ACTIVE);
    end

endmodule

// File: rtl/sc_char_engine.sv
module sc_char_engine
    import sc_pkg::*;
#(
    parameter int ETU_CLKS = 16,
    parameter int RETRY_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               t1_mode,
    input  logic [RETRY_W-1:0] retry_max,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    input  logic               io_in,
    output logic               io_drive_low,
    output logic               busy,
    output logic               rx_valid,
    output logic [7:0]         rx_data,
    output logic               rx_par_err,
    output logic               rx_err,
    output logic               tx_done,
    output logic               tx_fail,
    output logic               tx_giveup
);
    localparam int HALF = ETU_CLKS / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);

    chr_state_e st, st_nxt;
    logic [CW-1:0]      cyc;
    logic [4:0]         hcnt;
    logic               ht;
    logic               io_q, io_q2, fall;
    logic [9:0]         tx_frame;
    logic [8:0]         rx_sh;
    logic [RETRY_W-1:0] retries;
    logic               card_nak, retry_ok, rx_bad, restart;

    assign ht       = (cyc == HALF_LAST);
    assign fall     = io_q2 && !io_q;
    assign card_nak = (st == CH_TX_GUARD) && ht && (hcnt == HM_ERR_SENSE) && !t1_mode && !io_q;
    assign retry_ok = (retries < retry_max);
    assign rx_bad   = ^rx_sh;

    always_comb begin
        st_nxt = st;
        unique case (st)
            CH_IDLE:
                if (fall)       st_nxt = CH_RX_BITS;
                else if (wr_en) st_nxt = CH_TX_BITS;
            CH_TX_BITS:
                if (ht && hcnt == HM_TX_LAST) st_nxt = CH_TX_GUARD;
            CH_TX_GUARD:
                if (card_nak)                        st_nxt = retry_ok ? CH_TX_BACKOFF : CH_IDLE;
                else if (ht && hcnt == HM_GUARD_END) st_nxt = CH_IDLE;
            CH_TX_BACKOFF:
                if (ht && hcnt == HM_RETRY) st_nxt = CH_TX_BITS;
            CH_RX_BITS:
                if (ht && hcnt == HM_START_CHK && io_q) st_nxt = CH_IDLE;
                else if (ht && hcnt == HM_DECIDE)
                    st_nxt = (rx_bad && !t1_mode) ? CH_RX_NAK : CH_RX_GUARD;
            CH_RX_NAK:
                if (ht && hcnt == HM_NAK_END) st_nxt = CH_RX_GUARD;
            CH_RX_GUARD:
                if (ht && hcnt == HM_GUARD_END) st_nxt = CH_IDLE;
            default: st_nxt = CH_IDLE;
        endcase
        if (!en) st_nxt = CH_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CH_IDLE;
        else        st <= st_nxt;
    end

    assign restart = en && (((st == CH_IDLE) && (st_nxt != CH_IDLE)) ||
                            ((st == CH_TX_BACKOFF) && (st_nxt == CH_TX_BITS)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_q <= 1'b1; io_q2 <= 1'b1;
            cyc <= '0; hcnt <= '0;
            tx_frame <= '1; rx_sh <= '0; retries <= '0;
            rx_valid <= 1'b0; rx_data <= '0; rx_par_err <= 1'b0; rx_err <= 1'b0;
            tx_done <= 1'b0; tx_fail <= 1'b0; tx_giveup <= 1'b0;
        end else begin
            io_q  <= io_in;
            io_q2 <= io_q;
            rx_valid <= 1'b0; rx_err <= 1'b0; tx_done <= 1'b0; tx_fail <= 1'b0;
            if (restart) begin
                cyc <= '0; hcnt <= '0;
            end else if (ht) begin
                cyc <= '0; hcnt <= hcnt + 1'b1;
            end else begin
                cyc <= cyc + 1'b1;
            end
            if (st == CH_IDLE && st_nxt == CH_TX_BITS) begin
                tx_frame  <= {^wr_data, wr_data, 1'b0};
                retries   <= '0;
                tx_giveup <= 1'b0;
            end
            if (card_nak && en) begin
                if (retry_ok) retries <= retries + 1'b1;
                else begin
                    tx_fail   <= 1'b1;
                    tx_giveup <= 1'b1;
                end
            end
            if (en && st == CH_TX_GUARD && !card_nak && ht && hcnt == HM_GUARD_END)
                tx_done <= 1'b1;
            if (st == CH_RX_BITS && ht && hcnt[0] == 1'b0 && hcnt != HM_START_CHK &&
                hcnt < HM_DECIDE)
                rx_sh <= {io_q, rx_sh[8:1]};
            if (en && st == CH_RX_BITS && ht && hcnt == HM_DECIDE) begin
                if (rx_bad && !t1_mode) rx_err <= 1'b1;
                else begin
                    rx_valid   <= 1'b1;
                    rx_data    <= rx_sh[7:0];
                    rx_par_err <= rx_bad;
                end
            end
        end
    end

    always_comb begin
        io_drive_low = 1'b0;
        unique case (st)
            CH_TX_BITS: io_drive_low = !tx_frame[hcnt[4:1]];
            CH_RX_NAK:  io_drive_low = 1'b1;
            default:    io_drive_low = 1'b0;
        endcase
        busy = (st != CH_IDLE);
    end

endmodule

// File: rtl/sc_char_if.sv
module sc_char_if
    import sc_pkg::*;
#(
    parameter int ETU_CLKS      = 16,
    parameter int STEP_CLKS     = 4,
    parameter int RST_HOLD_CLKS = 20,
    parameter int RETRY_W       = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_up_req,
    input  logic               pwr_down_req,
    input  logic               cfg_t1,
    input  logic [RETRY_W-1:0] cfg_retry_max,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    input  logic               io_in,
    output logic               io_drive_low,
    output logic               card_gnd,
    output logic               card_vcc,
    output logic               card_clk_en,
    output logic               card_rst_n,
    output logic               card_ready,
    output logic               busy,
    output logic               rx_valid,
    output logic [7:0]         rx_data,
    output logic               rx_par_err,
    output logic               rx_err,
    output logic               tx_done,
    output logic               tx_fail,
    output logic               tx_giveup,
    output logic               irq
);

    sc_contact_seq #(
        .STEP_CLKS    (STEP_CLKS),
        .RST_HOLD_CLKS(RST_HOLD_CLKS)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_req    (pwr_up_req),
        .down_req  (pwr_down_req),
        .gnd_on    (card_gnd),
        .vcc_on    (card_vcc),
        .clk_on    (card_clk_en),
        .rst_card_n(card_rst_n),
        .ready     (card_ready)
    );

    sc_char_engine #(
        .ETU_CLKS(ETU_CLKS),
        .RETRY_W (RETRY_W)
    ) eng_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (card_ready),
        .t1_mode     (cfg_t1),
        .retry_max   (cfg_retry_max),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .io_in       (io_in),
        .io_drive_low(io_drive_low),
        .busy        (busy),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_par_err  (rx_par_err),
        .rx_err      (rx_err),
        .tx_done     (tx_done),
        .tx_fail     (tx_fail),
        .tx_giveup   (tx_giveup)
    );

    assign irq = rx_valid | rx_err | tx_done | tx_fail;

endmodule

// File: rtl/sc_char_if_chk.sv
module sc_char_if_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_t1,
    input logic card_gnd,
    input logic card_vcc,
    input logic card_clk_en,
    input logic card_rst_n,
    input logic card_ready,
    input logic busy,
    input logic rx_valid,
    input logic rx_err,
    input logic tx_done,
    input logic tx_fail,
    input logic tx_giveup
);

    // R1
    vcc_after_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_vcc) |-> card_gnd);

    // R1
    rst_release_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst_n) |-> (card_clk_en && card_vcc && card_gnd));

    // R2
    clk_stop_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_clk_en) |-> !card_rst_n);

    // R2
    vcc_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_vcc) |-> (!card_clk_en && !card_rst_n && card_gnd));

    // R4
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, rx_err, tx_done, tx_fail}));

    // R7
    giveup_with_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_giveup) |-> tx_fail);

    // R8
    no_err_block_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_t1 && $past(cfg_t1)) |-> !rx_err);

    // R9
    idle_when_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !card_ready |=> !busy);

endmodule

bind sc_char_if sc_char_if_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_t1     (cfg_t1),
    .card_gnd   (card_gnd),
    .card_vcc   (card_vcc),
    .card_clk_en(card_clk_en),
    .card_rst_n (card_rst_n),
    .card_ready (card_ready),
    .busy       (busy),
    .rx_valid   (rx_valid),
    .rx_err     (rx_err),
    .tx_done    (tx_done),
    .tx_fail    (tx_fail),
    .tx_giveup  (tx_giveup)
);

// File: tb/sc_char_if_tb_top.sv
`timescale 1ns/1ps
module sc_char_if_tb_top;
    localparam int ETU  = 16;
    localparam int STEP = 4;
    localparam int HOLD = 20;
    localparam int RW   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_up_req = 1'b0, pwr_down_req = 1'b0, cfg_t1 = 1'b0, wr_en = 1'b0;
    logic [RW-1:0] cfg_retry_max = 3'd3;
    logic [7:0] wr_data = 8'h00;
    logic card_low = 1'b0;
    logic line;
    logic io_drive_low, card_gnd, card_vcc, card_clk_en, card_rst_n, card_ready, busy;
    logic rx_valid, rx_par_err, rx_err, tx_done, tx_fail, tx_giveup, irq;
    logic [7:0] rx_data;

    always #2.5 clk = ~clk;
    assign line = !(io_drive_low || card_low);

    sc_char_if #(.ETU_CLKS(ETU), .STEP_CLKS(STEP), .RST_HOLD_CLKS(HOLD), .RETRY_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_up_req(pwr_up_req), .pwr_down_req(pwr_down_req),
        .cfg_t1(cfg_t1), .cfg_retry_max(cfg_retry_max), .wr_en(wr_en), .wr_data(wr_data),
        .io_in(line), .io_drive_low(io_drive_low), .card_gnd(card_gnd), .card_vcc(card_vcc),
        .card_clk_en(card_clk_en), .card_rst_n(card_rst_n), .card_ready(card_ready),
        .busy(busy), .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
        .rx_err(rx_err), .tx_done(tx_done), .tx_fail(tx_fail), .tx_giveup(tx_giveup), .irq(irq));

    int n_checks = 0, n_err = 0;
    int cycle = 0;
    int n_done = 0, n_fail = 0, n_rxerr = 0, dut_low_cycles = 0;
    int card_attempts = 0, nak_left = 0;
    bit card_tx_busy = 1'b0;
    bit last_nak = 1'b0;
    bit finished = 1'b0;
    int t_gnd_up, t_vcc_up, t_clk_up, t_rst_up, t_gnd_dn, t_vcc_dn, t_clk_dn, t_rst_dn;
    logic [8:0] exp_rx[$];
    logic [7:0] exp_card[$];
    logic [9:0] got;
    logic p_gnd = 0, p_vcc = 0, p_clk = 0, p_rst = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    endtask

    always @(posedge clk) cycle <= cycle + 1;

    // event and contact monitor
    always @(negedge clk) begin
        if (tx_done) n_done++;
        if (tx_fail) n_fail++;
        if (rx_err) n_rxerr++;
        if (io_drive_low) dut_low_cycles++;
        if (irq !== (rx_valid | rx_err | tx_done | tx_fail)) chk(0, "R4 irq", irq, 0);
        if (card_gnd && !p_gnd) t_gnd_up = cycle;
        if (card_vcc && !p_vcc) t_vcc_up = cycle;
        if (card_clk_en && !p_clk) t_clk_up = cycle;
        if (card_rst_n && !p_rst) t_rst_up = cycle;
        if (!card_gnd && p_gnd) t_gnd_dn = cycle;
        if (!card_vcc && p_vcc) t_vcc_dn = cycle;
        if (!card_clk_en && p_clk) t_clk_dn = cycle;
        if (!card_rst_n && p_rst) t_rst_dn = cycle;
        p_gnd = card_gnd; p_vcc = card_vcc; p_clk = card_clk_en; p_rst = card_rst_n;
    end

    // scoreboard monitor: bytes delivered to the host
    always @(negedge clk) begin
        if (rx_valid) begin
            if (exp_rx.size() == 0) chk(0, "R5 unexpected rx_valid", {rx_par_err, rx_data}, 0);
            else begin
                logic [8:0] e;
                e = exp_rx.pop_front();
                chk({rx_par_err, rx_data} == e, "R5/R8 rx byte", {rx_par_err, rx_data}, e);
            end
        end
    end

    // card receiver model and scoreboard for bytes sent by the block
    initial forever begin
        @(negedge clk);
        if (line == 1'b0 && !card_tx_busy) begin
            card_attempts++;
            for (int k = 0; k < 10; k++) begin
                repeat (k == 0 ? ETU/2 : ETU) @(negedge clk);
                got[k] = line;
            end
            repeat (ETU) @(negedge clk);
            if (nak_left > 0) begin
                nak_left--;
                card_low = 1'b1;
                repeat (3*ETU/2) @(negedge clk);
                card_low = 1'b0;
            end else begin
                chk(got[0] == 1'b0 && (^got[9:1]) == 1'b0, "R4 start/parity", got, 0);
                if (exp_card.size() == 0) chk(0, "R10 unexpected frame", got[8:1], 0);
                else begin
                    logic [7:0] e;
                    e = exp_card.pop_front();
                    chk(got[8:1] == e, "R4 tx byte", got[8:1], e);
                end
            end
        end
    end

    task automatic card_send(input logic [7:0] d, input bit bad);
        logic [9:0] fr;
        fr = {(^d) ^ bad, d, 1'b0};
        card_tx_busy = 1'b1;
        for (int i = 0; i < 10; i++) begin
            card_low = !fr[i];
            repeat (ETU) @(negedge clk);
        end
        card_low = 1'b0;
        repeat (ETU) @(negedge clk);
        last_nak = io_drive_low;
        repeat (3*ETU) @(negedge clk);
        card_tx_busy = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] d);
        wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (4) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2*ETU) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int d0, a0, f0, e0;
        repeat (5) @(negedge clk);
        // R3 reset state
        chk({card_gnd, card_vcc, card_clk_en, card_rst_n, io_drive_low, busy} == 6'b0,
            "R3 reset outputs", {card_gnd, card_vcc, card_clk_en, card_rst_n, io_drive_low, busy}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R9 write while contacts down
        host_write(8'h5A);
        repeat (300) @(negedge clk);
        chk(dut_low_cycles == 0 && n_done == 0, "R9 write ignored when down", dut_low_cycles, 0);

        // R1 power-up
        pwr_up_req = 1'b1; @(negedge clk); pwr_up_req = 1'b0;
        repeat (STEP*2 + HOLD + 10) @(negedge clk);
        chk(card_ready == 1'b1, "R1 ready", card_ready, 1);
        chk(t_vcc_up - t_gnd_up == STEP, "R1 gnd->vcc", t_vcc_up - t_gnd_up, STEP);
        chk(t_clk_up - t_vcc_up == STEP, "R1 vcc->clk", t_clk_up - t_vcc_up, STEP);
        chk(t_rst_up - t_clk_up == HOLD, "R1 clk->rst", t_rst_up - t_clk_up, HOLD);

        // R4 plain transmit
        d0 = n_done; a0 = card_attempts;
        exp_card.push_back(8'hA5);
        host_write(8'hA5);
        wait_idle();
        chk(n_done - d0 == 1, "R4 tx_done", n_done - d0, 1);
        chk(card_attempts - a0 == 1, "R4 single frame", card_attempts - a0, 1);

        // R7 two card errors then accepted
        d0 = n_done; a0 = card_attempts; f0 = n_fail;
        nak_left = 2;
        exp_card.push_back(8'h3C);
        host_write(8'h3C);
        wait_idle();
        chk(card_attempts - a0 == 3, "R7 resend count", card_attempts - a0, 3);
        chk(n_done - d0 == 1 && n_fail == f0, "R7 done after resend", n_done - d0, 1);

        // R7 retries exhausted
        d0 = n_done; a0 = card_attempts; f0 = n_fail;
        nak_left = 5;
        host_write(8'h96);
        wait_idle();
        chk(card_attempts - a0 == 4, "R7 attempts at limit", card_attempts - a0, 4);
        chk(n_fail - f0 == 1 && n_done == d0, "R7 tx_fail", n_fail - f0, 1);
        chk(tx_giveup == 1'b1, "R7 giveup set", tx_giveup, 1);
        nak_left = 0;
        exp_card.push_back(8'h0F);
        host_write(8'h0F);
        wait_idle();
        chk(tx_giveup == 1'b0, "R7 giveup cleared", tx_giveup, 0);

        // R5 good receive
        exp_rx.push_back({1'b0, 8'h3B});
        card_send(8'h3B, 1'b0);
        chk(last_nak == 1'b0, "R5 no error signal", last_nak, 0);
        chk(exp_rx.size() == 0, "R5 byte delivered", exp_rx.size(), 0);

        // R6 bad parity, character protocol
        e0 = n_rxerr;
        card_send(8'h5C, 1'b1);
        chk(last_nak == 1'b1, "R6 error signal driven", last_nak, 1);
        chk(n_rxerr - e0 == 1, "R6 rx_err", n_rxerr - e0, 1);

        // R8 block protocol
        cfg_t1 = 1'b1;
        e0 = n_rxerr;
        exp_rx.push_back({1'b1, 8'h5C});
        card_send(8'h5C, 1'b1);
        chk(last_nak == 1'b0, "R8 no error signal", last_nak, 0);
        chk(n_rxerr == e0 && exp_rx.size() == 0, "R8 reported with flag", n_rxerr - e0, 0);
        d0 = n_done; a0 = card_attempts;
        nak_left = 1;
        host_write(8'hC3);
        wait_idle();
        chk(card_attempts - a0 == 1 && n_done - d0 == 1, "R8 card error ignored",
            card_attempts - a0, 1);
        nak_left = 0;
        cfg_t1 = 1'b0;

        // R10 start edge and write in the same cycle
        d0 = n_done; a0 = card_attempts;
        exp_rx.push_back({1'b0, 8'h71});
        fork
            card_send(8'h71, 1'b0);
            begin
                @(negedge clk);
                host_write(8'hEE);
            end
        join
        wait_idle();
        chk(exp_rx.size() == 0, "R10 card byte received", exp_rx.size(), 0);
        chk(card_attempts == a0 && n_done == d0, "R10 write dropped", card_attempts - a0, 0);

        // R2 shutdown
        pwr_down_req = 1'b1; @(negedge clk); pwr_down_req = 1'b0;
        repeat (STEP*3 + 10) @(negedge clk);
        chk(card_ready == 1'b0 && card_gnd == 1'b0, "R2 all off", {card_ready, card_gnd}, 0);
        chk(t_clk_dn - t_rst_dn == STEP, "R2 rst->clk", t_clk_dn - t_rst_dn, STEP);
        chk(t_vcc_dn - t_clk_dn == STEP, "R2 clk->vcc", t_vcc_dn - t_clk_dn, STEP);
        chk(t_gnd_dn - t_vcc_dn == STEP, "R2 vcc->gnd", t_gnd_dn - t_vcc_dn, STEP);

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule